// File: doc/BRIEF.md
# Serial Bitstream Configuration Loader

This block loads a bitstream into a downstream programmable device over its passive serial configuration pins. A host drives it with a small command port: a begin command resets the target and waits until the target signals it is ready to accept data. A transfer command announces a byte count and then streams that many bytes through a byte port, each byte shifted out one bit at a time with a clock strobe. An end command samples the target's status and done pins and reports whether loading succeeded.

Every command except the no-op finishes with a one-cycle response carrying a one-bit result. The host issues a command only while `cmd_ready` is high. During a transfer it offers each byte with `byte_valid` and holds it until `byte_ready` accepts it. The 40 microsecond reset hold comes from a clock-frequency parameter. The strobe phase length and an optional ready-wait timeout are also parameters.

The controller is one state machine with these states:
- `S_IDLE` moves to `S_BEG_HOLD`, `S_XFER_RUN`, `S_END_EVAL` or `S_RESPOND` when a command is accepted. A zero-count transfer goes straight to `S_RESPOND`.
- `S_BEG_HOLD` moves to `S_BEG_WAIT` when the hold count ends.
- `S_BEG_WAIT` moves to `S_RESPOND` when the target reports ready or the timeout expires.
- `S_XFER_RUN` moves to `S_RESPOND` when all bytes are accepted and the shifter is idle.
- `S_END_EVAL` always moves to `S_RESPOND`.
- `S_RESPOND` always moves to `S_IDLE`.

Top module: `ps_cfg_loader`

## Requirements
- R1: After reset, `tgt_rst_n_o` is high, `tgt_dat_o` and `tgt_clk_o` are low, `busy` and `rsp_valid` are low, and `cmd_ready` is high.
- R2: A begin command drives `tgt_rst_n_o`, `tgt_dat_o` and `tgt_clk_o` low for exactly (CLK_HZ/1e6)*HOLD_US cycles, starting the cycle after acceptance. `tgt_rst_n_o` is then driven high.
- R3: After the reset release, the block waits while the two-flop-synchronised `tgt_stat_n_i` is low. Once it reads high, the block gives a response with result 1.
- R4: When TIMEOUT_CYC is nonzero and the status stays low for TIMEOUT_CYC cycles after release, the begin command responds with result 0.
- R5: Transfer bytes are shifted least significant bit first, with 8 rising edges of `tgt_clk_o` per byte. A byte is taken on a cycle where `byte_valid` and `byte_ready` are both high.
- R6: Each clock-high phase and each clock-low phase lasts HALF_CYC cycles. `tgt_dat_o` changes only while `tgt_clk_o` is low, so each bit is set up before its rising edge.
- R7: A transfer with count N accepts exactly N bytes and responds with result 1. A count of zero produces no clock pulse and responds with result 1.
- R8: If the synchronised status is low, an end command responds with result 0 whatever `tgt_done_i` is.
- R9: If the synchronised status is high, an end command responds with result 1 when synchronised `tgt_done_i` is high and 0 otherwise.
- R10: `busy` is high from the cycle after acceptance through the response cycle. `cmd_ready` is high only when `busy` is low. `rsp_valid` lasts a single cycle.
- R11: Command codes on `cmd_op` are 01 begin, 10 transfer, 11 end and 00 no-op. A no-op produces no response and leaves all outputs unchanged.
- R12: Outside a transfer, `byte_ready` is low and bytes offered on the byte port produce no clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Command code (01 begin, 10 transfer, 11 end, 00 no-op) |
| cmd_count | input | CNT_W | Byte count for a transfer command |
| cmd_ready | output | 1 | Controller idle, command accepted this cycle |
| byte_valid | input | 1 | Configuration byte present |
| byte_data | input | 8 | Configuration byte |
| byte_ready | output | 1 | Byte accepted this cycle |
| busy | output | 1 | A command is in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_result | output | 1 | Result of the command (1 success) |
| tgt_stat_n_i | input | 1 | Target status, active low (high means ready / no error) |
| tgt_done_i | input | 1 | Target reports loading complete |
| tgt_rst_n_o | output | 1 | Active-low configuration request to the target |
| tgt_dat_o | output | 1 | Serial configuration data |
| tgt_clk_o | output | 1 | Serial configuration clock |

## Verification
The bench counts the exact length of the reset hold. A controller off by one in its hold counter would release the request a cycle early or late. The bench holds the target's status low after release and confirms that no response appears until the status rises. A second begin keeps the status low, to show the timeout ends the command with a failure instead of hanging.

Transfer tests use bytes with the set bit at either end (0x01, 0x80) and alternating patterns. A shifter that sends the most significant bit first, or drops or repeats a bit, returns different bytes. The bench also measures the clock-high width and sends a zero-count transfer, which must produce no strobe. The end command is run in all four status/done combinations, so that reversed precedence between the two pins gives a wrong result.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_BEGIN = 2'b01,
        OP_XFER  = 2'b10,
        OP_END   = 2'b11
    } cfg_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BEG_HOLD,
        S_BEG_WAIT,
        S_XFER_RUN,
        S_END_EVAL,
        S_RESPOND
    } ldr_state_e;

endpackage

// File: rtl/ps_sync2.sv
module ps_sync2 #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    // Two flops per line; each line gets its own chain.
    for (genvar g = 0; g < W; g++) begin : g_line
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_i[g];
                stab_q <= meta_q;
            end
        end
        assign sync_o[g] = stab_q;
    end

endmodule

// File: rtl/ps_delay_timer.sv
module ps_delay_timer #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_q;

    // Counts cycles since the last clear; saturates at the top value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/ps_bit_shifter.sv
module ps_bit_shifter #(
    parameter int unsigned DW       = 8,
    parameter int unsigned HALF_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] din_i,
    output logic          ready_o,
    output logic          idle_o,
    output logic          sclk_o,
    output logic          sdat_o
);

    localparam int unsigned PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int unsigned BW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [PW-1:0] PH_LAST  = PW'(HALF_CYC - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

    logic          active_q;
    logic          hi_q;
    logic [PW-1:0] pc_q;
    logic [BW-1:0] bi_q;
    logic [DW-1:0] sh_q;
    logic          last_ph;

    assign last_ph = (pc_q == PH_LAST);

    // Per bit: a low phase with data presented, then a high phase.
    // Data moves to the next bit only as the clock returns low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            hi_q     <= 1'b0;
            pc_q     <= '0;
            bi_q     <= '0;
            sh_q     <= '0;
        end else if (load_i) begin
            active_q <= 1'b1;
            hi_q     <= 1'b0;
            pc_q     <= '0;
            bi_q     <= '0;
            sh_q     <= din_i;
        end else if (active_q) begin
            if (!last_ph) begin
                pc_q <= pc_q + 1'b1;
            end else begin
                pc_q <= '0;
                if (!hi_q) begin
                    hi_q <= 1'b1;
                end else begin
                    hi_q <= 1'b0;
                    sh_q <= sh_q >> 1;
                    if (bi_q == BIT_LAST) begin
                        active_q <= 1'b0;
                    end else begin
                        bi_q <= bi_q + 1'b1;
                    end
                end
            end
        end
    end

    assign ready_o = !active_q || (hi_q && last_ph && (bi_q == BIT_LAST));
    assign idle_o  = !active_q;
    assign sclk_o  = hi_q;
    assign sdat_o  = sh_q[0];

endmodule

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader
    import ps_cfg_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 100_000_000,
    parameter int unsigned HOLD_US     = 40,
    parameter int unsigned HALF_CYC    = 2,
    parameter int unsigned TIMEOUT_CYC = 0,
    parameter int unsigned CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [CNT_W-1:0] cmd_count,
    output logic             cmd_ready,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    output logic             byte_ready,
    output logic             busy,
    output logic             rsp_valid,
    output logic             rsp_result,
    input  logic             tgt_stat_n_i,
    input  logic             tgt_done_i,
    output logic             tgt_rst_n_o,
    output logic             tgt_dat_o,
    output logic             tgt_clk_o
);

    localparam int unsigned HOLD_CYC = (CLK_HZ / 1_000_000) * HOLD_US;
    localparam int unsigned SPAN     = (HOLD_CYC > TIMEOUT_CYC) ? HOLD_CYC : TIMEOUT_CYC;
    localparam int unsigned TMR_W    = $clog2(SPAN + 2);
    localparam logic [TMR_W-1:0] HOLD_LAST = TMR_W'(HOLD_CYC - 1);

    ldr_state_e       state_q, state_d;
    cfg_op_e          op;
    logic [1:0]       pins_sync;
    logic             stat_ok, done_ok;
    logic [TMR_W-1:0] tmr_cnt;
    logic             tmr_clr;
    logic             wait_expired;
    logic [CNT_W-1:0] rem_q;
    logic             res_q;
    logic             req_n_q;
    logic             sh_load, sh_ready, sh_idle;
    logic             accept;

    assign op      = cfg_op_e'(cmd_op);
    assign accept  = (state_q == S_IDLE) && cmd_valid;
    assign stat_ok = pins_sync[0];
    assign done_ok = pins_sync[1];

    ps_sync2 #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({tgt_done_i, tgt_stat_n_i}),
        .sync_o  (pins_sync)
    );

    // Restarted on every state change, so it measures time spent in a state.
    assign tmr_clr = (state_d != state_q);

    ps_delay_timer #(.W(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .cnt_o (tmr_cnt)
    );

    if (TIMEOUT_CYC > 0) begin : g_tmo
        localparam logic [TMR_W-1:0] TMO_LAST = TMR_W'(TIMEOUT_CYC - 1);
        assign wait_expired = (state_q == S_BEG_WAIT) && (tmr_cnt == TMO_LAST);
    end else begin : g_no_tmo
        assign wait_expired = 1'b0;
    end

    assign sh_load = (state_q == S_XFER_RUN) && (rem_q != '0) && sh_ready && byte_valid;

    ps_bit_shifter #(.DW(8), .HALF_CYC(HALF_CYC)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .din_i   (byte_data),
        .ready_o (sh_ready),
        .idle_o  (sh_idle),
        .sclk_o  (tgt_clk_o),
        .sdat_o  (tgt_dat_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    case (op)
                        OP_BEGIN: state_d = S_BEG_HOLD;
                        OP_XFER:  state_d = (cmd_count == '0) ? S_RESPOND : S_XFER_RUN;
                        OP_END:   state_d = S_END_EVAL;
                        default:  state_d = S_IDLE;
                    endcase
                end
            end
            S_BEG_HOLD: if (tmr_cnt == HOLD_LAST) state_d = S_BEG_WAIT;
            S_BEG_WAIT: if (stat_ok || wait_expired) state_d = S_RESPOND;
            S_XFER_RUN: if ((rem_q == '0) && sh_idle) state_d = S_RESPOND;
            S_END_EVAL: state_d = S_RESPOND;
            S_RESPOND:  state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // Byte counter and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            res_q <= 1'b0;
        end else begin
            if (accept && (op == OP_XFER)) begin
                rem_q <= cmd_count;
                res_q <= 1'b1;
            end else if (sh_load) begin
                rem_q <= rem_q - 1'b1;
            end
            if (state_q == S_BEG_WAIT) begin
                if (stat_ok)           res_q <= 1'b1;
                else if (wait_expired) res_q <= 1'b0;
            end
            if (state_q == S_END_EVAL) begin
                res_q <= stat_ok && done_ok;
            end
        end
    end

    // Output process: the request pin is registered, so it cannot glitch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_n_q <= 1'b1;
        end else begin
            req_n_q <= (state_d != S_BEG_HOLD);
        end
    end

    assign tgt_rst_n_o = req_n_q;
    assign cmd_ready   = (state_q == S_IDLE);
    assign busy        = (state_q != S_IDLE);
    assign rsp_valid   = (state_q == S_RESPOND);
    assign rsp_result  = (state_q == S_RESPOND) && res_q;
    assign byte_ready  = (state_q == S_XFER_RUN) && (rem_q != '0) && sh_ready;

endmodule

// File: rtl/ps_cfg_loader_chk.sv
module ps_cfg_loader_chk #(
    parameter int unsigned HOLD_CYC = 4000,
    parameter int unsigned HALF_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_ready,
    input logic byte_ready,
    input logic busy,
    input logic rsp_valid,
    input logic tgt_rst_n_o,
    input logic tgt_dat_o,
    input logic tgt_clk_o
);

    logic [31:0] lo_len;
    logic [31:0] hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_len <= '0;
            hi_len <= '0;
        end else begin
            lo_len <= tgt_rst_n_o ? 32'd0 : lo_len + 32'd1;
            hi_len <= tgt_clk_o ? hi_len + 32'd1 : 32'd0;
        end
    end

    // R2
    hold_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_rst_n_o) |-> (lo_len == HOLD_CYC));

    // R2
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_rst_n_o |-> (!tgt_clk_o && !tgt_dat_o));

    // R6
    high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tgt_clk_o) |-> (hi_len == HALF_CYC));

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_clk_o && $past(tgt_clk_o)) |-> $stable(tgt_dat_o));

    // R10
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10
    rsp_in_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy);

    // R10
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !busy);

    // R12
    byte_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> busy);

    // R12
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_clk_o) |-> busy);

endmodule

bind ps_cfg_loader ps_cfg_loader_chk #(
    .HOLD_CYC (HOLD_CYC),
    .HALF_CYC (HALF_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_ready   (cmd_ready),
    .byte_ready  (byte_ready),
    .busy        (busy),
    .rsp_valid   (rsp_valid),
    .tgt_rst_n_o (tgt_rst_n_o),
    .tgt_dat_o   (tgt_dat_o),
    .tgt_clk_o   (tgt_clk_o)
);

// File: tb/tb_ps_cfg_loader.sv
`timescale 1ns/1ps
module tb_ps_cfg_loader;

    localparam int HALF   = 2;
    localparam int TMO    = 500;
    localparam int HOLD_E = 100 * 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [7:0] cmd_count = 8'd0;
    logic       cmd_ready;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'd0;
    logic       byte_ready;
    logic       busy, rsp_valid, rsp_result;
    logic       stat_n = 1'b0;
    logic       done = 1'b0;
    logic       req_n, tdat, tclk;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ps_cfg_loader #(
        .CLK_HZ(100_000_000), .HOLD_US(40), .HALF_CYC(HALF),
        .TIMEOUT_CYC(TMO), .CNT_W(8)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_count(cmd_count), .cmd_ready(cmd_ready), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_ready(byte_ready), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_result(rsp_result), .tgt_stat_n_i(stat_n),
        .tgt_done_i(done), .tgt_rst_n_o(req_n), .tgt_dat_o(tdat), .tgt_clk_o(tclk)
    );

    // Serial receiver model: capture on each rising strobe, LSB first.
    logic [7:0] rx_sh = 8'd0;
    logic [7:0] rx_buf [16];
    int rx_bits = 0;
    int rx_n = 0;
    always @(posedge tclk) begin
        rx_sh = {tdat, rx_sh[7:1]};
        rx_bits++;
        if (rx_bits % 8 == 0 && rx_n < 16) begin
            rx_buf[rx_n] = rx_sh;
            rx_n++;
        end
    end

    int hi_run = 0;
    int last_hi = 0;
    always @(negedge clk) begin
        if (tclk) hi_run++;
        else if (hi_run > 0) begin
            last_hi = hi_run;
            hi_run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    // Issue a command from a negedge; returns at the negedge after acceptance.
    task automatic issue(input logic [1:0] op, input logic [7:0] cnt);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_count = cnt;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_rsp(input int limit, output bit got, output bit res);
        got = 1'b0;
        res = 1'b0;
        for (int i = 0; i < limit && !got; i++) begin
            if (rsp_valid) begin
                got = 1'b1;
                res = rsp_result;
            end else begin
                @(negedge clk);
            end
        end
        if (got) begin
            @(negedge clk);
            chk(!rsp_valid, "R10 single-cycle response", rsp_valid, 0);
            chk(cmd_ready && !busy, "R10 idle after response", busy, 0);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        byte_valid = 1'b1;
        byte_data  = b;
        while (!byte_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_n == 1'b1, "R1 request high", req_n, 1);
        chk(!tdat && !tclk, "R1 data/clock low", {tdat, tclk}, 0);
        chk(!busy && !rsp_valid, "R1 not busy", {busy, rsp_valid}, 0);
        chk(cmd_ready, "R1 command ready", cmd_ready, 1);
    endtask

    task automatic t_begin_ok();
        int lo = 0;
        bit quiet = 1'b1;
        bit early = 1'b0;
        bit got, res;
        stat_n = 1'b0;
        issue(2'b01, 8'd0);
        chk(busy, "R10 busy during begin", busy, 1);
        while (!req_n && lo < HOLD_E + 100) begin
            lo++;
            if (tdat || tclk) quiet = 1'b0;
            @(negedge clk);
        end
        chk(lo == HOLD_E, "R2 hold length", lo, HOLD_E);
        chk(quiet, "R2 data/clock low in hold", quiet, 1);
        for (int i = 0; i < 30; i++) begin
            if (rsp_valid || !busy) early = 1'b1;
            @(negedge clk);
        end
        chk(!early, "R3 waits for status", early, 0);
        stat_n = 1'b1;
        wait_rsp(20, got, res);
        chk(got && res, "R3 begin result", {got, res}, 3);
    endtask

    task automatic t_begin_timeout();
        bit got, res;
        stat_n = 1'b0;
        repeat (4) @(negedge clk);
        issue(2'b01, 8'd0);
        wait_rsp(HOLD_E + TMO + 50, got, res);
        chk(got && !res, "R4 timeout result", {got, res}, 2);
    endtask

    task automatic t_xfer();
        bit got, res;
        logic [7:0] pat [4] = '{8'hA5, 8'h3C, 8'h01, 8'h80};
        rx_bits = 0;
        rx_n = 0;
        issue(2'b10, 8'd4);
        for (int i = 0; i < 4; i++) send_byte(pat[i]);
        wait_rsp(200, got, res);
        chk(got && res, "R7 transfer result", {got, res}, 3);
        chk(rx_bits == 32, "R5 strobe count", rx_bits, 32);
        for (int i = 0; i < 4; i++)
            chk(rx_buf[i] == pat[i], "R5 byte LSB first", rx_buf[i], pat[i]);
        chk(last_hi == HALF, "R6 clock high width", last_hi, HALF);
    endtask

    task automatic t_xfer_zero();
        bit got, res;
        rx_bits = 0;
        issue(2'b10, 8'd0);
        wait_rsp(20, got, res);
        chk(got && res, "R7 zero-count result", {got, res}, 3);
        chk(rx_bits == 0, "R7 zero-count no strobe", rx_bits, 0);
    endtask

    task automatic t_end(input bit sn, input bit dn, input bit exp, input string req);
        bit got, res;
        stat_n = sn;
        done   = dn;
        repeat (4) @(negedge clk);
        issue(2'b11, 8'd0);
        wait_rsp(20, got, res);
        chk(got && (res == exp), req, {got, res}, {1'b1, exp});
    endtask

    task automatic t_noop();
        bit seen = 1'b0;
        issue(2'b00, 8'd7);
        for (int i = 0; i < 20; i++) begin
            if (rsp_valid || busy || !req_n || tclk) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R11 no-op has no effect", seen, 0);
    endtask

    task automatic t_stray_byte();
        bit rdy = 1'b0;
        rx_bits = 0;
        byte_valid = 1'b1;
        byte_data  = 8'hFF;
        for (int i = 0; i < 40; i++) begin
            if (byte_ready) rdy = 1'b1;
            @(negedge clk);
        end
        byte_valid = 1'b0;
        repeat (10) @(negedge clk);
        chk(!rdy, "R12 byte_ready low outside transfer", rdy, 0);
        chk(rx_bits == 0, "R12 stray byte no strobe", rx_bits, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_noop();
        t_stray_byte();
        t_begin_ok();
        t_xfer();
        t_xfer_zero();
        t_end(1'b0, 1'b1, 1'b0, "R8 status low, done high");
        t_end(1'b0, 1'b0, 1'b0, "R8 status low, done low");
        t_end(1'b1, 1'b0, 1'b0, "R9 status high, done low");
        t_end(1'b1, 1'b1, 1'b1, "R9 status high, done high");
        t_begin_timeout();
        summary();
    end

endmodule